// File: doc/BRIEF.md
# Condition Flag Register and Branch Condition Evaluator

This unit holds the four condition flags of a small processor core: zero (Z), sign (S), carry (C) and overflow (V). They sit apart from the general register file. Only an instruction that sets flags changes them, and such an instruction signals this by raising a flag-write strobe together with the new flag values. The unit captures the values on the next rising clock edge.

Alongside the register, a purely combinational path takes the 4-bit condition field of a conditional jump and reports whether the jump is taken. It judges the condition against the flags already held in the register. Computing the jump target and updating the program counter are left to the fetch logic that uses the taken result.

The condition map is fixed. The signed comparisons test S against C instead of S against V. Two pairs of codes decode the same way: 0x2 with 0x4, and 0xA with 0xC. Codes 0x8 to 0xF are the logical complements of codes 0x0 to 0x7.

Top module: `cc_unit`

## Requirements
- R1: When `rst` is high at a rising clock edge, all four held flags read 0 after that edge. Reset takes priority over `flag_we`.
- R2: When `flag_we` is high and `rst` is low at a rising clock edge, the held flags take the values of `zf_in`, `sf_in`, `cf_in` and `vf_in` after that edge.
- R3: When both `flag_we` and `rst` are low at a rising clock edge, the held flags keep their values. The incoming flag inputs then have no effect.
- R4: `taken` is a combinational function of `cond_code` and the held flags only. Flag values presented with `flag_we` high do not affect `taken` until after the capturing edge.
- R5: Code 0x0 is never taken and code 0x8 is always taken.
- R6: Code 0x1 is taken when Z=1, and code 0x9 is taken when Z=0.
- R7: Codes 0x2 and 0x4 are both taken when Z=1 or when S differs from C.
- R8: Code 0x3 is taken when S differs from C, and code 0xB is taken when S equals C.
- R9: Codes 0xA and 0xC are both taken when Z=0 and S equals C.
- R10: Codes 0x5 and 0xD test V set and V clear. Codes 0x6 and 0xE test S set and S clear. Codes 0x7 and 0xF test C set and C clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| flag_we | input | 1 | Flag-write strobe from the ALU |
| zf_in | input | 1 | Incoming zero flag |
| sf_in | input | 1 | Incoming sign flag |
| cf_in | input | 1 | Incoming carry flag |
| vf_in | input | 1 | Incoming overflow flag |
| cond_code | input | 4 | Condition field of the conditional jump |
| zf | output | 1 | Held zero flag |
| sf | output | 1 | Held sign flag |
| cf | output | 1 | Held carry flag |
| vf | output | 1 | Held overflow flag |
| taken | output | 1 | Jump condition satisfied by the held flags |

## Verification
A flag write or a reset shows on the flag outputs exactly one clock edge after the cycle that carries it. The bench compares the held flags at the falling edge after each rising edge, against a model updated on that same rising edge. `taken` has no register in its path. It is checked 1 ns after each new condition code and set of incoming flags is driven, in the same cycle. The expected result uses the flags held before any pending write, so a mismatch caused by incoming flags leaking through is caught in the very cycle it happens. Every code is swept against all sixteen flag patterns, and a randomised phase then mixes writes, holds and resets.

// File: rtl/cc_pkg.sv
package cc_pkg;

  localparam int unsigned COND_W  = 4;
  localparam int unsigned FLAG_N  = 4;

  typedef struct packed {
    logic z;
    logic s;
    logic c;
    logic v;
  } flags_t;

  typedef enum logic [COND_W-1:0] {
    JC_NEVER   = 4'h0,
    JC_ZERO    = 4'h1,
    JC_SLE     = 4'h2,
    JC_SLT     = 4'h3,
    JC_SLE_DUP = 4'h4,
    JC_OVF     = 4'h5,
    JC_MINUS   = 4'h6,
    JC_CARRY   = 4'h7,
    JC_ALWAYS  = 4'h8,
    JC_NZERO   = 4'h9,
    JC_SGT     = 4'hA,
    JC_SGE     = 4'hB,
    JC_SGT_DUP = 4'hC,
    JC_NOVF    = 4'hD,
    JC_PLUS    = 4'hE,
    JC_NCARRY  = 4'hF
  } jcond_e;

  // Signed "less" as this core defines it: sign against carry.
  function automatic logic sign_carry_differ(input flags_t f);
    return f.s ^ f.c;
  endfunction

  function automatic logic cond_met(input jcond_e code, input flags_t f);
    logic lt;
    lt = sign_carry_differ(f);
    case (code)
      JC_NEVER:   return 1'b0;
      JC_ZERO:    return f.z;
      JC_SLE:     return f.z | lt;
      JC_SLT:     return lt;
      JC_SLE_DUP: return f.z | lt;
      JC_OVF:     return f.v;
      JC_MINUS:   return f.s;
      JC_CARRY:   return f.c;
      JC_ALWAYS:  return 1'b1;
      JC_NZERO:   return ~f.z;
      JC_SGT:     return ~f.z & ~lt;
      JC_SGE:     return ~lt;
      JC_SGT_DUP: return ~f.z & ~lt;
      JC_NOVF:    return ~f.v;
      JC_PLUS:    return ~f.s;
      JC_NCARRY:  return ~f.c;
      default:    return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/cc_flag_store.sv
module cc_flag_store #(
  parameter int unsigned W = cc_pkg::FLAG_N
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)       q[i] <= 1'b0;
      else if (load) q[i] <= d[i];
    end
  end
endmodule

// File: rtl/cc_cond_eval.sv
module cc_cond_eval
  import cc_pkg::*;
(
  input  logic [COND_W-1:0] code,
  input  flags_t            flags,
  output logic              taken
);
  always_comb taken = cond_met(jcond_e'(code), flags);
endmodule

// File: rtl/cc_unit.sv
module cc_unit
  import cc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              flag_we,
  input  logic              zf_in,
  input  logic              sf_in,
  input  logic              cf_in,
  input  logic              vf_in,
  input  logic [COND_W-1:0] cond_code,
  output logic              zf,
  output logic              sf,
  output logic              cf,
  output logic              vf,
  output logic              taken
);
  flags_t flags_d;
  flags_t flags_q;
  logic   load_evt;

  assign flags_d  = '{z: zf_in, s: sf_in, c: cf_in, v: vf_in};
  assign load_evt = flag_we & ~rst;

  cc_flag_store #(.W(FLAG_N)) u_store (
    .clk  (clk),
    .rst  (rst),
    .load (flag_we),
    .d    (flags_d),
    .q    (flags_q)
  );

  cc_cond_eval u_eval (
    .code  (cond_code),
    .flags (flags_q),
    .taken (taken)
  );

  assign zf = flags_q.z;
  assign sf = flags_q.s;
  assign cf = flags_q.c;
  assign vf = flags_q.v;
endmodule

// File: rtl/cc_unit_chk.sv
module cc_unit_chk (
  input logic       clk,
  input logic       rst,
  input logic       load_evt,
  input logic       zf_in,
  input logic       sf_in,
  input logic       cf_in,
  input logic       vf_in,
  input logic [3:0] cond_code,
  input logic       zf,
  input logic       sf,
  input logic       cf,
  input logic       vf,
  input logic       taken
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> {zf, sf, cf, vf} == 4'b0000);

  // R2
  flag_load_chk: assert property (@(posedge clk) disable iff (rst)
    load_evt |=> {zf, sf, cf, vf} == $past({zf_in, sf_in, cf_in, vf_in}));

  // R3
  flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !load_evt |=> $stable({zf, sf, cf, vf}));

  // R5
  never_taken_chk: assert property (@(posedge clk) disable iff (rst)
    cond_code == 4'h0 |-> !taken);

  // R5
  always_taken_chk: assert property (@(posedge clk) disable iff (rst)
    cond_code == 4'h8 |-> taken);

  // R6
  zero_cond_chk: assert property (@(posedge clk) disable iff (rst)
    cond_code == 4'h1 |-> taken == zf);

  // R8
  signed_lt_chk: assert property (@(posedge clk) disable iff (rst)
    cond_code == 4'h3 |-> taken == (sf != cf));

  // R10
  carry_cond_chk: assert property (@(posedge clk) disable iff (rst)
    cond_code == 4'h7 |-> taken == cf);
endmodule

bind cc_unit cc_unit_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .load_evt  (load_evt),
  .zf_in     (zf_in),
  .sf_in     (sf_in),
  .cf_in     (cf_in),
  .vf_in     (vf_in),
  .cond_code (cond_code),
  .zf        (zf),
  .sf        (sf),
  .cf        (cf),
  .vf        (vf),
  .taken     (taken)
);

// File: tb/sim_cc_unit.sv
`timescale 1ns/1ps
module sim_cc_unit;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic flag_we = 1'b0;
  logic zf_in = 1'b0, sf_in = 1'b0, cf_in = 1'b0, vf_in = 1'b0;
  logic [3:0] cond_code = 4'h0;
  logic zf, sf, cf, vf, taken;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // reference state, ordered z,s,c,v
  bit [3:0] m_flags = 4'b0000;
  bit       prev_rst = 1'b1;
  bit       prev_we  = 1'b0;

  always #4 clk = ~clk;

  cc_unit u0 (
    .clk(clk), .rst(rst), .flag_we(flag_we),
    .zf_in(zf_in), .sf_in(sf_in), .cf_in(cf_in), .vf_in(vf_in),
    .cond_code(cond_code),
    .zf(zf), .sf(sf), .cf(cf), .vf(vf), .taken(taken)
  );

  always @(posedge clk) begin
    prev_rst <= rst;
    prev_we  <= flag_we;
    if (rst)          m_flags <= 4'b0000;
    else if (flag_we) m_flags <= {zf_in, sf_in, cf_in, vf_in};
  end

  // Upper half of the map is the complement of the lower half.
  function automatic bit ref_taken(input int code, input bit [3:0] f);
    bit z, s, c, v, lt, base;
    z = f[3]; s = f[2]; c = f[1]; v = f[0];
    lt = (s != c);
    case (code % 8)
      0: base = 0;
      1: base = z;
      2: base = z || lt;
      3: base = lt;
      4: base = z || lt;
      5: base = v;
      6: base = s;
      default: base = c;
    endcase
    return (code >= 8) ? !base : base;
  endfunction

  function automatic string req_of(input int code);
    case (code)
      0, 8:        return "R5";
      1, 9:        return "R6";
      2, 4:        return "R7";
      3, 11:       return "R8";
      10, 12:      return "R9";
      default:     return "R10";
    endcase
  endfunction

  task automatic check_flags();
    string rq;
    checks++;
    rq = prev_rst ? "R1" : (prev_we ? "R2" : "R3");
    if ({zf, sf, cf, vf} !== m_flags) begin
      errors++;
      $display("FAIL %s flags actual=%b expected=%b", rq, {zf, sf, cf, vf}, m_flags);
    end
  endtask

  task automatic check_taken();
    bit exp;
    string rq;
    exp = ref_taken(int'(cond_code), m_flags);
    rq = flag_we ? {req_of(int'(cond_code)), "/R4"} : req_of(int'(cond_code));
    checks++;
    if (taken !== exp) begin
      errors++;
      $display("FAIL %s taken code=%h flags=%b actual=%b expected=%b",
               rq, cond_code, m_flags, taken, exp);
    end
  endtask

  task automatic cyc(input bit r, input bit we, input bit [3:0] fin, input bit [3:0] code);
    @(negedge clk);
    check_flags();
    rst = r; flag_we = we;
    {zf_in, sf_in, cf_in, vf_in} = fin;
    cond_code = code;
    #1;
    check_taken();
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R1: reset with write requested must still clear
    cyc(1, 1, 4'b1111, 4'h8);
    cyc(1, 1, 4'b1111, 4'h0);
    cyc(0, 0, 4'b1111, 4'h1);
    cyc(0, 0, 4'b0000, 4'h9);

    // sweep every pattern and code; inputs inverted while holding (R3, R4)
    for (int f = 0; f < 16; f++) begin
      cyc(0, 1, 4'(f), 4'h8);
      for (int c = 0; c < 16; c++) begin
        cyc(0, 0, ~4'(f), 4'(c));
      end
      // R4: write pending in this cycle, taken still uses old flags
      cyc(0, 1, ~4'(f), 4'h1);
      cyc(0, 0, 4'(f), 4'h3);
    end

    // random mix of writes, holds and occasional resets
    for (int i = 0; i < 400; i++) begin
      cyc(($urandom % 23) == 0, ($urandom % 2) == 1, 4'($urandom), 4'($urandom));
    end

    cyc(0, 0, 4'b0000, 4'h0);
    @(negedge clk);
    check_flags();

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule